// File: doc/BRIEF.md
# Phase Detector with Lock Judgement and One-Shot Fast-Lock Control

This block sits between the reference divider and the feedback divider of a frequency synthesizer. It watches the rising edges of the reference pulse and the feedback pulse and turns their timing difference into charge-pump commands. Only one command can be active at a time: pump up when the reference edge arrived first, or pump down when the feedback edge arrived first. When neither command is active, the pump output is high-impedance. Each command lasts as many oscillator cycles as the two edges are apart. Both pulse inputs are sampled on the oscillator clock, which is the only clock of the block.

A lock-indicator output goes low while an error is being pumped, or it can be held low to keep it quiet. A fast-lock output is driven only during the first acquisition after reset. That interval opens at the first detected edge and closes once the error width has stayed inside a four-cycle window for four comparisons in a row. It never opens again before the next reset. While the interval is open, a boost request input can raise a current-boost enable with the same timing. A test input reroutes the lock indicator to a raw divider pulse and, in one setting, forces the fast-lock output on.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: A rising edge on `ref_pls` that arrives d cycles before the matching `fb_pls` edge makes `pump_up` high for exactly d consecutive cycles. It rises on the clock edge that samples the reference rising edge, and `pump_dn` stays low throughout.
- R2: A rising edge on `fb_pls` that arrives d cycles before the matching `ref_pls` edge makes `pump_dn` high for exactly d cycles in the same way, and `pump_up` stays low throughout.
- R3: `pump_up` and `pump_dn` are never high together. Edges that arrive in the same cycle produce neither command. After both edges are held, the detector clears in the next cycle. A new edge that is sampled during that clearing cycle still starts the next comparison.
- R4: With `test_mode`=0 and `ld_ctl`=1, `lock_n` is the inverse of (`pump_up` OR `pump_dn`) in every cycle.
- R5: With `test_mode`=0 and `ld_ctl`=0, `lock_n` is held at 0.
- R6: A comparison is counted as good when its error width is at most WIN_CYC (4) cycles. Lock is reached after LOCK_RUNS (4) good comparisons in a row, and any wider comparison restarts the count. The fast-lock interval ends in the cycle after the comparison that reaches lock.
- R7: After reset, `fl_oe` and `fl_out` are 0 until the first edge is held by the detector. Both are then 1 until the interval ends under R6. When not driven, the fast-lock output counts as high-impedance.
- R8: Once the fast-lock interval has ended, it does not restart before the next reset, even after lock has been lost and regained.
- R9: `boost_en` is 1 exactly in the cycles where the fast-lock interval is open and `boost_req` is 1.
- R10: With `test_mode`=1 and `tst_sel`=0, `lock_n` equals `fb_pls` combinationally, and `fl_oe` and `fl_out` are forced to 1.
- R11: With `test_mode`=1 and `tst_sel`=1, `lock_n` equals `ref_pls` combinationally, and `fl_oe` and `fl_out` follow R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pls | input | 1 | Reference divider pulse |
| fb_pls | input | 1 | Feedback divider pulse |
| ld_ctl | input | 1 | 1 enables the lock indicator, 0 holds it low |
| tst_sel | input | 1 | Test source select for the lock indicator |
| boost_req | input | 1 | Requests extra pump current during fast lock |
| test_mode | input | 1 | Test pin that reroutes the lock indicator and fast-lock outputs |
| pump_up | output | 1 | Charge-pump source command |
| pump_dn | output | 1 | Charge-pump sink command |
| lock_n | output | 1 | Lock indicator, low while an error is pumped |
| fl_out | output | 1 | Fast-lock output level |
| fl_oe | output | 1 | Fast-lock output drive enable |
| boost_en | output | 1 | Pump current boost enable |

## Verification
Two of the block's functions can fall in the same cycle: the clearing of a finished comparison and the start of the next one. The bench provokes this by sending pulse pairs whose period is one cycle longer than their lag, so the next reference edge is sampled in the clearing cycle. The edge must not be lost, and the next pump command must start on schedule. The end of the fast-lock interval also comes in the cycle right after the judged comparison, and it is checked against a behavioural model that follows comparisons, counts and interval state on every clock.

// File: rtl/pfd_pkg.sv
// Shared types for the phase detector with lock and fast-lock control.
package pfd_pkg;
    // Phase of the one-shot fast-lock sequence.
    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_ACTIVE = 2'd1,
        FL_SPENT  = 2'd2
    } fl_state_e;

    // Source that drives the lock indicator.
    typedef enum logic [1:0] {
        LDSRC_ERR = 2'd0,
        LDSRC_LOW = 2'd1,
        LDSRC_FB  = 2'd2,
        LDSRC_REF = 2'd3
    } ld_src_e;
endpackage

// File: rtl/pfd_edge_cmp.sv
// Edge comparator: latches the rising edges of the reference and feedback
// pulses and derives the three-state pump commands from them.
// Assumes: both pulses are synchronous to clk and stay low for at least one
// cycle between edges. Once both edges are held, the latches clear in the
// next cycle, and a new edge sampled during that clearing cycle is kept.
module pfd_edge_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pls,
    input  logic fb_pls,
    output logic up,
    output logic dn,
    output logic busy,
    output logic done
);
    localparam int NCH = 2;   // channel 0 = reference, channel 1 = feedback

    logic [NCH-1:0] pls_in;
    logic [NCH-1:0] pls_prev;
    logic [NCH-1:0] pls_rise;
    logic [NCH-1:0] pls_lat;
    logic           both;

    assign pls_in = {fb_pls, ref_pls};
    assign both   = &pls_lat;

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            // Rising edge of this channel, seen against last cycle's level.
            assign pls_rise[ch] = pls_in[ch] & ~pls_prev[ch];

            // Hold the edge until both channels have arrived, then clear it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pls_prev[ch] <= 1'b0;
                    pls_lat[ch]  <= 1'b0;
                end else begin
                    pls_prev[ch] <= pls_in[ch];
                    pls_lat[ch]  <= pls_rise[ch] | (pls_lat[ch] & ~both);
                end
            end
        end
    endgenerate

    assign up   = pls_lat[0] & ~pls_lat[1];
    assign dn   = pls_lat[1] & ~pls_lat[0];
    assign busy = |pls_lat;
    assign done = both;
endmodule

// File: rtl/pfd_lock_judge.sv
// Lock judge: measures the error width of each comparison and counts
// comparisons in a row whose width fits the window.
// Assumes: done is high for one cycle per finished comparison, and err is
// low in that cycle.
module pfd_lock_judge #(
    parameter int WIN_CYC   = 4,
    parameter int LOCK_RUNS = 4,
    parameter int MAX_ERR   = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic done,
    output logic locked
);
    localparam int CW = $clog2(MAX_ERR + 1);
    localparam int GW = $clog2(LOCK_RUNS + 1);

    logic [CW-1:0] err_len;
    logic [GW-1:0] good_runs;
    logic          in_win;

    assign in_win = (err_len <= CW'(WIN_CYC));

    // Count the pump cycles of the current comparison, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_len <= '0;
        end else if (done) begin
            err_len <= '0;
        end else if (err && (err_len != CW'(MAX_ERR))) begin
            err_len <= err_len + 1'b1;
        end
    end

    // Track good comparisons in a row; a wide one restarts the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_runs <= '0;
        end else if (done) begin
            if (!in_win) begin
                good_runs <= '0;
            end else if (good_runs != GW'(LOCK_RUNS)) begin
                good_runs <= good_runs + 1'b1;
            end
        end
    end

    assign locked = (good_runs == GW'(LOCK_RUNS));
endmodule

// File: rtl/pfd_fastlock_seq.sv
// One-shot fast-lock sequencer: the interval opens at the first held edge
// after reset and closes for good once lock is reached.
// Assumes: lock cannot be reached before any edge is held.
module pfd_fastlock_seq (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               locked,
    output logic               active,
    output pfd_pkg::fl_state_e state
);
    import pfd_pkg::*;

    fl_state_e state_q;
    fl_state_e state_d;

    // Next state: idle waits for activity, active waits for lock, spent stays.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:   if (busy)   state_d = FL_ACTIVE;
            FL_ACTIVE: if (locked) state_d = FL_SPENT;
            FL_SPENT:  state_d = FL_SPENT;
            default:   state_d = FL_SPENT;
        endcase
    end

    // State register; only reset brings the sequence back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    assign active = (state_q == FL_ACTIVE);
    assign state  = state_q;
endmodule

// File: rtl/pfd_out_mux.sv
// Output selection: picks the lock-indicator source and the fast-lock and
// boost outputs from the test controls.
// Assumes: raw pulse inputs may pass combinationally in test mode.
module pfd_out_mux (
    input  logic ld_ctl,
    input  logic tst_sel,
    input  logic test_mode,
    input  logic boost_req,
    input  logic err,
    input  logic ref_pls,
    input  logic fb_pls,
    input  logic fl_active,
    output logic lock_n,
    output logic fl_out,
    output logic fl_oe,
    output logic boost_en
);
    import pfd_pkg::*;

    ld_src_e src;
    logic    force_fl;

    // Choose where the lock indicator comes from.
    always_comb begin
        if (test_mode) src = tst_sel ? LDSRC_REF : LDSRC_FB;
        else           src = ld_ctl  ? LDSRC_ERR : LDSRC_LOW;
    end

    // Drive the lock indicator from the chosen source.
    always_comb begin
        unique case (src)
            LDSRC_ERR: lock_n = ~err;
            LDSRC_LOW: lock_n = 1'b0;
            LDSRC_FB:  lock_n = fb_pls;
            LDSRC_REF: lock_n = ref_pls;
            default:   lock_n = 1'b0;
        endcase
    end

    assign force_fl = test_mode & ~tst_sel;
    assign fl_oe    = force_fl | fl_active;
    assign fl_out   = fl_oe;
    assign boost_en = boost_req & fl_active;
endmodule

// File: rtl/pfd_lock_ctrl.sv
// Top: phase detector with lock judgement and one-shot fast-lock control.
// Assumes: a single oscillator clock domain and divider pulses synchronous to
// it. A pump output is high-impedance when neither command is active; the
// fast-lock output is high-impedance when fl_oe is low.
module pfd_lock_ctrl #(
    parameter int WIN_CYC   = 4,
    parameter int LOCK_RUNS = 4,
    parameter int MAX_ERR   = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pls,
    input  logic fb_pls,
    input  logic ld_ctl,
    input  logic tst_sel,
    input  logic boost_req,
    input  logic test_mode,
    output logic pump_up,
    output logic pump_dn,
    output logic lock_n,
    output logic fl_out,
    output logic fl_oe,
    output logic boost_en
);
    import pfd_pkg::*;

    logic      up_w, dn_w, busy_w, done_w, err_w, locked_w, fl_act_w;
    fl_state_e fl_st;

    pfd_edge_cmp u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_pls (ref_pls),
        .fb_pls  (fb_pls),
        .up      (up_w),
        .dn      (dn_w),
        .busy    (busy_w),
        .done    (done_w)
    );

    assign err_w = up_w | dn_w;

    pfd_lock_judge #(
        .WIN_CYC   (WIN_CYC),
        .LOCK_RUNS (LOCK_RUNS),
        .MAX_ERR   (MAX_ERR)
    ) u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .err    (err_w),
        .done   (done_w),
        .locked (locked_w)
    );

    pfd_fastlock_seq u_fl (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy_w),
        .locked (locked_w),
        .active (fl_act_w),
        .state  (fl_st)
    );

    pfd_out_mux u_mux (
        .ld_ctl    (ld_ctl),
        .tst_sel   (tst_sel),
        .test_mode (test_mode),
        .boost_req (boost_req),
        .err       (err_w),
        .ref_pls   (ref_pls),
        .fb_pls    (fb_pls),
        .fl_active (fl_act_w),
        .lock_n    (lock_n),
        .fl_out    (fl_out),
        .fl_oe     (fl_oe),
        .boost_en  (boost_en)
    );

    assign pump_up = up_w;
    assign pump_dn = dn_w;
endmodule

// File: rtl/pfd_lock_ctrl_chk.sv
// Checker for pfd_lock_ctrl: port and state relations over time.
module pfd_lock_ctrl_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_ctl,
    input logic               tst_sel,
    input logic               boost_req,
    input logic               test_mode,
    input logic               pump_up,
    input logic               pump_dn,
    input logic               lock_n,
    input logic               fl_out,
    input logic               fl_oe,
    input logic               boost_en,
    input pfd_pkg::fl_state_e fl_st
);
    import pfd_pkg::*;

    AST_PUMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn)); // R3

    AST_LD_FOLLOWS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && ld_ctl) |-> (lock_n == !(pump_up || pump_dn))); // R4

    AST_LD_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode && !ld_ctl) |-> !lock_n); // R5

    AST_FL_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_st == FL_SPENT) |=> (fl_st == FL_SPENT)); // R8

    AST_FL_QUIET_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_st == FL_SPENT && !test_mode) |-> (!fl_oe && !boost_en)); // R7

    AST_BOOST_IN_FL: assert property (@(posedge clk) disable iff (!rst_n)
        boost_en |-> (boost_req && fl_st == FL_ACTIVE)); // R9

    AST_TEST_FL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !tst_sel) |-> (fl_oe && fl_out)); // R10
endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_ctl    (ld_ctl),
    .tst_sel   (tst_sel),
    .boost_req (boost_req),
    .test_mode (test_mode),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .lock_n    (lock_n),
    .fl_out    (fl_out),
    .fl_oe     (fl_oe),
    .boost_en  (boost_en),
    .fl_st     (fl_st)
);

// File: tb/sim_pfd_lock_ctrl.sv
// Bench for pfd_lock_ctrl: a behavioural model stepped on every clock and
// compared on every falling edge.
module sim_pfd_lock_ctrl;
    localparam int CLK_PER = 10;
    localparam int WIN     = 4;
    localparam int RUNS    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pls = 1'b0, fb_pls = 1'b0;
    logic ld_ctl = 1'b1, tst_sel = 1'b0, boost_req = 1'b1, test_mode = 1'b0;
    logic pump_up, pump_dn, lock_n, fl_out, fl_oe, boost_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PER/2) clk = ~clk;

    pfd_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .fb_pls(fb_pls),
        .ld_ctl(ld_ctl), .tst_sel(tst_sel), .boost_req(boost_req),
        .test_mode(test_mode), .pump_up(pump_up), .pump_dn(pump_dn),
        .lock_n(lock_n), .fl_out(fl_out), .fl_oe(fl_oe), .boost_en(boost_en)
    );

    // Behavioural model state
    bit m_rp, m_fp, m_u, m_d;      // previous pulse levels, held edges
    int m_w, m_good, m_st;         // error width, good run, 0 idle 1 active 2 spent
    bit n_u, n_d, frr, fnr, both, merr, lk;
    int n_w, n_good, n_st;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rp = 0; m_fp = 0; m_u = 0; m_d = 0; m_w = 0; m_good = 0; m_st = 0;
        end else begin
            frr  = ref_pls && !m_rp;
            fnr  = fb_pls && !m_fp;
            both = m_u && m_d;
            merr = m_u ^ m_d;
            lk   = (m_good >= RUNS);
            n_st = m_st;
            if (m_st == 0 && (m_u || m_d)) n_st = 1;
            else if (m_st == 1 && lk) n_st = 2;
            if (both) begin
                n_w = 0;
                n_good = (m_w <= WIN) ? ((m_good + 1 > RUNS) ? RUNS : m_good + 1) : 0;
            end else begin
                n_w = m_w + (merr ? 1 : 0);
                n_good = m_good;
            end
            n_u = frr || (m_u && !both);
            n_d = fnr || (m_d && !both);
            m_rp = ref_pls; m_fp = fb_pls;
            m_u = n_u; m_d = n_d; m_w = n_w; m_good = n_good; m_st = n_st;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    logic e_up, e_dn, e_ld, e_oe, e_bst;
    always @(negedge clk) begin
        if (rst_n) begin
            e_up = m_u && !m_d;
            e_dn = m_d && !m_u;
            e_oe = (test_mode && !tst_sel) || (m_st == 1);
            e_bst = boost_req && (m_st == 1);
            chk(pump_up, e_up, "R1 pump_up");
            chk(pump_dn, e_dn, "R2 pump_dn");
            chk(pump_up && pump_dn, 1'b0, "R3 exclusive");
            if (test_mode) begin
                e_ld = tst_sel ? ref_pls : fb_pls;
                if (tst_sel) chk(lock_n, e_ld, "R11 lock_n");
                else         chk(lock_n, e_ld, "R10 lock_n");
            end else if (ld_ctl) begin
                e_ld = !(e_up || e_dn);
                chk(lock_n, e_ld, "R4 lock_n");
            end else begin
                chk(lock_n, 1'b0, "R5 lock_n");
            end
            chk(fl_oe, e_oe, "R7 fl_oe");
            chk(fl_out, e_oe, "R7 fl_out");
            chk(boost_en, e_bst, "R9 boost_en");
        end
    end

    task automatic cyc(input logic r, input logic f);
        @(posedge clk); #2;
        ref_pls = r; fb_pls = f;
    endtask

    // One pulse pair: reference pulse at index a, feedback at index b.
    task automatic pair(input int a, input int b, input int per);
        for (int i = 0; i < per; i++) cyc(i == a, i == b);
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst_n = 0; ref_pls = 0; fb_pls = 0;
        repeat (3) @(posedge clk);
        #2; rst_n = 1;
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk(pump_up, 1'b0, "R1 reset");
        chk(pump_dn, 1'b0, "R2 reset");
        chk(lock_n, 1'b1, "R4 reset");
        chk(fl_oe, 1'b0, "R7 reset");
        chk(boost_en, 1'b0, "R9 reset");

        // Wide errors: fast lock opens, no lock yet (R6, R7)
        for (int k = 0; k < 3; k++) pair(0, 7, 16);
        @(negedge clk); chk(fl_oe, 1'b1, "R6 not yet locked");
        // Four good comparisons, both leads
        pair(0, 3, 12); pair(0, 3, 12); pair(2, 0, 12); pair(1, 0, 12);
        repeat (2) @(negedge clk);
        chk(fl_oe, 1'b0, "R6 interval ended at lock");
        // Lose lock then regain: no re-arm (R8)
        pair(0, 9, 16); pair(9, 0, 16);
        @(negedge clk); chk(fl_oe, 1'b0, "R8 no re-arm after loss");
        for (int k = 0; k < 5; k++) pair(0, 1, 8);
        @(negedge clk); chk(fl_oe, 1'b0, "R8 no re-arm after regain");
        // Simultaneous edges (R3)
        pair(0, 0, 8); pair(3, 3, 8);
        // Back-to-back: new reference edge in the clearing cycle (R3)
        for (int k = 0; k < 4; k++) pair(0, 3, 4);
        for (int k = 0; k < 3; k++) pair(0, 2, 3);
        cyc(0, 0); cyc(0, 0);

        // Fresh start with boost off, then on mid-interval (R9)
        boost_req = 0;
        do_reset();
        pair(0, 5, 12); pair(0, 6, 12);
        boost_req = 1;
        pair(0, 5, 12);
        @(negedge clk); chk(boost_en, 1'b1, "R9 boost during interval");
        boost_req = 0;
        pair(3, 0, 12);

        // Lock indicator held low (R5)
        ld_ctl = 0;
        pair(0, 4, 10); pair(4, 0, 10);
        ld_ctl = 1;

        // Test mode, feedback source with forced fast-lock (R10)
        test_mode = 1; tst_sel = 0;
        pair(0, 3, 10); pair(2, 5, 10);
        // Test mode, reference source with normal fast-lock (R11)
        tst_sel = 1;
        pair(0, 3, 10); pair(4, 1, 10);
        do_reset();
        pair(0, 2, 10);
        @(negedge clk); chk(fl_oe, 1'b1, "R11 normal fast lock");
        test_mode = 0;
        pair(0, 2, 10);

        repeat (3) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule